// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is one stage of a synchronous binary up-counter, four bits wide by default. Every state bit changes on the same rising clock edge. Three inputs steer the next state: an active-low parallel load, and two active-high count enables called `en_p` and `en_t`. An active-low clear forces the count to zero at once, without waiting for a clock edge.

The stage drives a carry output. This output is high while the count sits at its all-ones value and `en_t` is high. It is pure combinational logic from the register state and `en_t`. A wider counter is built by wiring each stage's `carry_out` to the `en_t` of the next stage. All stages share the clock, the clear, the load and `en_p`, and no extra gating or pipeline cycle is needed.

Every pin is a plain level control or data bus sampled at the clock edge. There is no handshake and no back-pressure. The count presented on `q` is simply the register contents.

Top module: `casc_bin_counter`

## Requirements
- R1: All bits of `q` (bit 0 is the least significant bit of an unsigned binary count) change together on a single rising edge of `clk`.
- R2: While `clr_n` is low, `q` is zero within the same time step, independent of `clk`, `load_n`, `en_p` and `en_t`. A clock edge during clear does not load or count.
- R3: When `load_n` is low at a rising edge, `q` takes the value on `d` (any value 0 to 2^WIDTH-1), whatever the levels of `en_p` and `en_t`.
- R4: When `load_n` is high and both `en_p` and `en_t` are high at a rising edge, `q` becomes `q+1`.
- R5: When `load_n` is high and either enable is low at a rising edge, `q` keeps its value.
- R6: `carry_out` is 1 exactly when `q` is all ones and `en_t` is 1. It follows `en_t` and `q` combinationally and does not depend on `en_p`.
- R7: Counting from the all-ones value wraps `q` to zero, and `carry_out` falls on that same edge.
- R8: Stages chained through `carry_out` into `en_t`, with shared clock, clear, load and `en_p`, form a wider synchronous binary counter that increments in one cycle across every stage boundary, including full rollover.
- R9: Changes on `load_n`, `en_p`, `en_t` and `d` between rising edges have no effect on `q`. Only their values at the edge matter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| d | input | WIDTH | Preset value for the load |
| en_p | input | 1 | Count enable that does not affect the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| q | output | WIDTH | Current count |
| carry_out | output | 1 | High while the count is all ones and `en_t` is high |

## Verification
Several patterns exercise the stage, and each one separates a different mistake.

- Loads are applied with both enables low and with both high. This separates "load wins over the enables" from "load only when enabled".
- Each enable is held low in turn, at the all-ones value. This tells apart a counter that gates on only one enable from a correct one. It also shows whether the carry wrongly follows `en_p` or ignores `en_t`.
- A count runs across the wrap and through a value where all bits flip at once. This exposes wrong increment and wrap behaviour.
- Controls are pulsed to their active levels between edges. This exposes any sensitivity to control changes between edges.
- A clear is applied in the middle of a cycle while a load is pending, which tests both the immediacy and the priority of the clear.
- Three stages are chained into a 12-bit counter and run through a full rollover. A carry that is late by a cycle, or gated by the wrong enable, shows up as a mismatch against the 12-bit model.

// File: rtl/casc_cnt_pkg.sv
package casc_cnt_pkg;

  typedef enum logic [1:0] {
    CM_HOLD  = 2'd0,
    CM_COUNT = 2'd1,
    CM_LOAD  = 2'd2
  } cnt_mode_e;

endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
  import casc_cnt_pkg::*;
(
  input  logic      load_n,
  input  logic      en_p,
  input  logic      en_t,
  output cnt_mode_e mode
);

  // Load outranks counting; counting needs both enables.
  always_comb begin
    if (!load_n)
      mode = CM_LOAD;
    else if (en_p && en_t)
      mode = CM_COUNT;
    else
      mode = CM_HOLD;
  end

endmodule

// File: rtl/cnt_next_val.sv
module cnt_next_val
  import casc_cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_mode_e        mode,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] nxt
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    case (mode)
      CM_LOAD:  nxt = preset;
      CM_COUNT: nxt = cur + ONE;
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] cur
);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)
      cur <= '0;
    else
      cur <= nxt;
  end

endmodule

// File: rtl/cnt_carry_gen.sv
module cnt_carry_gen #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             en_t,
  output logic             carry
);

  // Prefix AND: ones_upto[i] is high when bits 0..i are all ones.
  logic [WIDTH-1:0] ones_upto;

  assign ones_upto[0] = cur[0];

  genvar gi;
  generate
    for (gi = 1; gi < WIDTH; gi++) begin : g_prefix
      assign ones_upto[gi] = ones_upto[gi-1] & cur[gi];
    end
  endgenerate

  assign carry = en_t & ones_upto[WIDTH-1];

endmodule

// File: rtl/casc_bin_counter.sv
module casc_bin_counter
  import casc_cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] d,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] q,
  output logic             carry_out
);

  cnt_mode_e        mode;
  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] cur;

  cnt_mode_dec u_dec (
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .mode   (mode)
  );

  cnt_next_val #(.WIDTH(WIDTH)) u_nxt (
    .mode   (mode),
    .cur    (cur),
    .preset (d),
    .nxt    (nxt)
  );

  cnt_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .nxt   (nxt),
    .cur   (cur)
  );

  cnt_carry_gen #(.WIDTH(WIDTH)) u_cy (
    .cur   (cur),
    .en_t  (en_t),
    .carry (carry_out)
  );

  assign q = cur;

endmodule

// File: rtl/casc_bin_counter_chk.sv
module casc_bin_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic [WIDTH-1:0] d,
  input logic             en_p,
  input logic             en_t,
  input logic [WIDTH-1:0] q,
  input logic             carry_out
);

  localparam logic [WIDTH-1:0] ALL1 = '1;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  // R2: this property checks the clear itself, so it cannot be disabled by it.
  a_r2_clear_zero: assert property (@(posedge clk)
    !clr_n |-> (q == '0));

  // R3
  a_r3_load: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> (q == $past(d)));

  // R4
  a_r4_count: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t) |=> (q == $past(q) + ONE));

  // R5
  a_r5_hold: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_p && en_t)) |=> $stable(q));

  // R6
  a_r6_carry_at_max: assert property (@(posedge clk) disable iff (!clr_n)
    (en_t && (q == ALL1)) |-> carry_out);

  // R6
  a_r6_carry_gated: assert property (@(posedge clk) disable iff (!clr_n)
    !en_t |-> !carry_out);

  // R7
  a_r7_wrap: assert property (@(posedge clk) disable iff (!clr_n)
    (carry_out && en_p && load_n) |=> ((q == '0) && !carry_out));

endmodule

bind casc_bin_counter casc_bin_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .load_n    (load_n),
  .d         (d),
  .en_p      (en_p),
  .en_t      (en_t),
  .q         (q),
  .carry_out (carry_out)
);

// File: tb/sim_casc_bin_counter.sv
module sim_casc_bin_counter;

  logic        clk = 1'b0;
  logic        clr_n;
  logic        load_n;
  logic [3:0]  d;
  logic        en_p;
  logic        en_t;
  logic [3:0]  q;
  logic        carry_out;

  // 12-bit chain of three stages
  logic [11:0] cd;
  logic [11:0] cq;
  logic [2:0]  cco;
  logic [2:0]  cet;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  casc_bin_counter #(.WIDTH(4)) u0 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .d(d),
    .en_p(en_p), .en_t(en_t), .q(q), .carry_out(carry_out)
  );

  assign cet[0] = en_t;
  genvar gk;
  generate
    for (gk = 0; gk < 3; gk++) begin : g_chain
      if (gk > 0) begin : g_link
        assign cet[gk] = cco[gk-1];
      end
      casc_bin_counter #(.WIDTH(4)) u_st (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .d(cd[4*gk +: 4]),
        .en_p(en_p), .en_t(cet[gk]), .q(cq[4*gk +: 4]), .carry_out(cco[gk])
      );
    end
  endgenerate

  typedef struct {
    logic [3:0]  q;
    logic        c;
    logic [11:0] cq;
    logic        cc;
    string       tag;
  } exp_t;

  exp_t sb[$];

  // reference model state and the inputs applied for the next edge
  logic [3:0]  m_q  = '0;
  logic [11:0] m_cq = '0;
  bit          p_ld = 1'b1;
  logic [3:0]  p_d  = '0;
  logic [11:0] p_cd = '0;
  bit          p_ep = 1'b0;
  bit          p_et = 1'b0;
  string       p_tag = "init";

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // apply the model's rule to the edge that just happened
  task automatic upd();
    if (!p_ld) begin
      m_q  = p_d;
      m_cq = p_cd;
    end else if (p_ep && p_et) begin
      m_q  = m_q + 4'd1;
      m_cq = m_cq + 12'd1;
    end
  endtask

  task automatic drive(input bit ld, input logic [3:0] dv, input bit ep, input bit et);
    load_n = ld;
    d      = dv;
    cd     = {dv, ~dv, dv};
    en_p   = ep;
    en_t   = et;
    p_ld = ld; p_d = dv; p_cd = {dv, ~dv, dv}; p_ep = ep; p_et = et;
  endtask

  // driver: one cycle of stimulus; pushes the expected result of the previous edge
  task automatic step(input bit ld, input logic [3:0] dv, input bit ep, input bit et,
                      input bit glitch, input string tag);
    exp_t e;
    @(posedge clk);
    #2;
    upd();
    e.tag = p_tag;
    drive(ld, dv, ep, et);
    p_tag = tag;
    e.q  = m_q;
    e.c  = et && (m_q == 4'hF);
    e.cq = m_cq;
    e.cc = et && (m_cq == 12'hFFF);
    sb.push_back(e);
    if (glitch) begin
      // R9: pulse every control to its active level between edges
      #1;
      load_n = 1'b0; en_p = 1'b1; en_t = 1'b1; d = ~dv; cd = ~cd;
      #1;
      drive(ld, dv, ep, et);
    end
  endtask

  // monitor: compares at the falling edge, away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(q == e.q, e.tag, "count", 32'(q), 32'(e.q));
      check(carry_out == e.c, "R6", {"carry after ", e.tag}, 32'(carry_out), 32'(e.c));
      check(cq == e.cq, "R8", {"chain count after ", e.tag}, 32'(cq), 32'(e.cq));
      check(cco[2] == e.cc, "R8", {"chain carry after ", e.tag}, 32'(cco[2]), 32'(e.cc));
    end
  end

  // R2: clear in mid-cycle with a load pending
  task automatic mid_clear();
    @(posedge clk);
    #2;
    upd();
    drive(1'b0, 4'h5, 1'b1, 1'b1);
    #1 clr_n = 1'b0;
    #1;
    check(q == 4'h0, "R2", "immediate clear", 32'(q), 32'h0);
    check(cq == 12'h0, "R2", "immediate clear chain", 32'(cq), 32'h0);
    @(posedge clk);
    #1;
    check(q == 4'h0, "R2", "clear beats load at edge", 32'(q), 32'h0);
    check(cq == 12'h0, "R2", "clear beats load chain", 32'(cq), 32'h0);
    #1;
    drive(1'b1, 4'h0, 1'b0, 1'b0);
    clr_n = 1'b1;
    m_q  = '0;
    m_cq = '0;
    p_tag = "R2 after clear";
  endtask

  initial begin
    clr_n = 1'b0;
    drive(1'b1, 4'h0, 1'b0, 1'b1);
    #3;
    check(q == 4'h0, "R2", "reset state", 32'(q), 32'h0);
    check(carry_out == 1'b0, "R6", "reset carry", 32'(carry_out), 32'h0);
    @(posedge clk);
    #1;
    check(q == 4'h0, "R2", "held through edge", 32'(q), 32'h0);
    @(posedge clk);
    #2;
    clr_n = 1'b1;
    drive(1'b1, 4'h0, 1'b0, 1'b0);

    step(1'b0, 4'h9, 1'b0, 1'b0, 1'b0, "R3 load enables low");
    step(1'b0, 4'hF, 1'b1, 1'b1, 1'b0, "R3 load enables high");
    step(1'b1, 4'h0, 1'b0, 1'b1, 1'b0, "R5 hold en_p low");
    step(1'b1, 4'h0, 1'b1, 1'b0, 1'b0, "R5 hold en_t low");
    step(1'b1, 4'h0, 1'b1, 1'b1, 1'b0, "R7 wrap");
    step(1'b0, 4'h7, 1'b0, 1'b0, 1'b0, "R3 load 7");
    step(1'b1, 4'h0, 1'b1, 1'b1, 1'b0, "R1 R4 all bits flip");
    step(1'b0, 4'hD, 1'b0, 1'b0, 1'b0, "R3 load 13");
    for (int i = 0; i < 4; i++)
      step(1'b1, 4'h0, 1'b1, 1'b1, 1'b0, "R4 R7 count over wrap");
    step(1'b0, 4'h0, 1'b0, 1'b0, 1'b0, "R3 load 0");
    step(1'b1, 4'h3, 1'b0, 1'b0, 1'b1, "R9 glitch on hold");
    step(1'b1, 4'h3, 1'b0, 1'b0, 1'b1, "R9 glitch on hold");
    step(1'b1, 4'h0, 1'b0, 1'b0, 1'b0, "R5 hold");
    @(negedge clk);
    mid_clear();

    step(1'b0, 4'h0, 1'b0, 1'b0, 1'b0, "R3 load 0");
    for (int i = 0; i < 4100; i++)
      step(1'b1, 4'h0, 1'b1, 1'b1, 1'b0, "R8 rollover");
    step(1'b1, 4'h0, 1'b0, 1'b0, 1'b0, "R5 final hold");
    step(1'b1, 4'h0, 1'b0, 1'b0, 1'b0, "R5 final hold");
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule